// File: doc/BRIEF.md
# SAR converter control sequencer

This block is the digital half of an eight-channel, 12-bit successive-approximation converter that sits on a byte-wide processor bus. The host writes one control byte. The byte picks the input channel, the span and polarity, how the acquisition window is timed and the power state. The sequencer then runs a sampling window and steps a 12-bit trial code, one bit per converter clock. It uses a single comparator bit for each decision. When the code is resolved it lowers an interrupt, and the host reads the result back in two bus cycles.

The write, read, chip-select and shutdown pins are asynchronous to the converter clock. They are synchronised and edge-detected inside the block. The data bus is modelled as a separate input byte, output byte and output enable, and the enable goes high only during a selected read. The analog mux, track/hold, trial DAC and reference sit outside the block. They are driven from `chan_sel`, `range_hi`, `bipolar`, `track` and `dac_code`.

Top module: `adc_sar_sequencer`

## Requirements
- R1: A write latches the byte. Bits [2:0] give the channel on `chan_sel`, bit 3 drives `bipolar`, bit 4 drives `range_hi` and bit 5 selects the externally closed acquisition.
- R2: Bits [7:6] are the power code. 00 selects the external clock (`int_clk_sel`=0) and 01 selects the internal clock (`int_clk_sel`=1). 10 requests standby and 11 requests full power-down, and both leave `int_clk_sel` unchanged.
- R3: With bit 5 clear, the write's rising edge opens a window in which `track` is high for exactly 6 clocks. Conversion follows, and `irq_n` falls on the 21st clock edge after the strobe rises (3 synchroniser edges, 6 acquisition, 12 conversion).
- R4: With bit 5 set, `track` stays high with no time limit. A later write with bit 5 set keeps it open. A later write with bit 5 clear starts conversion, and `irq_n` falls 15 edges after that strobe rises.
- R5: Conversion lasts 12 clocks and resolves bit 11 down to bit 0. The first trial code is 0x800, and a trial bit is kept when `comp` is 1.
- R6: `irq_n` resets high and falls when a result is stored. It returns high 3 edges after a selected read falling edge or a selected write rising edge.
- R7: A write whose rising edge lands during a conversion, including its final clock, cancels that conversion. No interrupt is raised, the previously stored result stays readable, and a new acquisition starts.
- R8: A standby or full power-down request takes effect only when the conversion started by that write completes (`pd_standby` or `pd_full` high). The next selected write falling edge wakes the block, and results stay readable while powered down.
- R9: While `shdn_n` is low, the block reaches full power-down within 3 edges and any conversion is cancelled without an interrupt. Writes are ignored. Releasing `shdn_n` returns the block to idle.
- R10: `dout_oe` is high only while `cs_n` and `rd_n` are both low. With `byte_hi`=0, `dout` carries result bits 7..0. With `byte_hi`=1, `dout[3:0]` carries bits 11..8 and `dout[7:4]` repeats bit 11 when `bipolar`=1 or is zero when `bipolar`=0.
- R11: After reset the block is idle with the external clock, no power-down, `track` low and `irq_n` high.
- R12: Write and read strobes are ignored while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | converter clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cs_n | input | 1 | chip select, active low, asynchronous |
| wr_n | input | 1 | write strobe, active low, asynchronous |
| rd_n | input | 1 | read strobe, active low, asynchronous |
| byte_hi | input | 1 | read half select: 0 low byte, 1 high nibble |
| shdn_n | input | 1 | hardware shutdown, active low |
| din | input | 8 | control byte from the bus |
| comp | input | 1 | comparator: 1 when input is at or above the trial code |
| dout | output | 8 | read data toward the bus |
| dout_oe | output | 1 | bus drive enable |
| irq_n | output | 1 | result-ready interrupt, active low |
| chan_sel | output | 3 | selected input channel |
| range_hi | output | 1 | wide span selected |
| bipolar | output | 1 | two's-complement span selected |
| int_clk_sel | output | 1 | internal clock selected |
| track | output | 1 | track/hold in tracking |
| dac_code | output | 12 | current trial code, zero outside conversion |
| pd_standby | output | 1 | standby power-down active |
| pd_full | output | 1 | full power-down active |

## Verification
A write can be detected in the same clock in which the stepper resolves bit 0. Both then try to decide the next state, the interrupt and the stored result. The bench provokes this in external-acquisition mode by letting a third strobe rise exactly 12 clocks after the strobe that started conversion. It then requires that `irq_n` never falls, that a read still returns the earlier result, and that `track` rises for the new window. A completion racing a read falling edge is judged the same way: the interrupt of the new result must survive.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    // control byte field positions
    localparam int CB_CH_LSB = 0;
    localparam int CB_CH_W   = 3;
    localparam int CB_BIP    = 3;
    localparam int CB_RNG    = 4;
    localparam int CB_ACQ    = 5;
    localparam int CB_PD_LSB = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQI,
        ST_ACQE,
        ST_CONV,
        ST_STBY,
        ST_FULL
    } seq_state_e;
endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic shdn_n,
    output logic wr_rise,
    output logic wr_fall,
    output logic wr_low,
    output logic rd_fall,
    output logic shdn_lo
);
    // bit order of the synchroniser vector
    localparam int NSIG = 4;
    localparam int I_CS = 0;
    localparam int I_WR = 1;
    localparam int I_RD = 2;
    localparam int I_SD = 3;

    typedef struct packed {
        logic [STAGES-1:0][NSIG-1:0] pipe;
        logic [NSIG-1:0]             prev;
    } sync_regs_t;

    sync_regs_t r_d, r_q;
    logic [NSIG-1:0] raw, now_s;

    assign raw   = {shdn_n, rd_n, wr_n, cs_n};
    assign now_s = r_q.pipe[STAGES-1];

    always_comb begin
        r_d = r_q;
        r_d.pipe[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            r_d.pipe[i] = r_q.pipe[i-1];
        end
        r_d.prev = now_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_rise = now_s[I_WR] & ~r_q.prev[I_WR] & ~now_s[I_CS];
    assign wr_fall = ~now_s[I_WR] & r_q.prev[I_WR] & ~now_s[I_CS];
    assign rd_fall = ~now_s[I_RD] & r_q.prev[I_RD] & ~now_s[I_CS];
    assign wr_low  = ~now_s[I_WR];
    assign shdn_lo = ~now_s[I_SD];
endmodule

// File: rtl/sar_stepper.sv
module sar_stepper #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cancel,
    input  logic         comp,
    output logic [W-1:0] trial,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] final_code
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [W-1:0]  acc;
    } step_regs_t;

    step_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.busy = 1'b1;
            r_d.idx  = IW'(W - 1);
            r_d.acc  = '0;
        end else if (cancel) begin
            r_d.busy = 1'b0;
        end else if (r_q.busy) begin
            r_d.acc[r_q.idx] = comp;
            if (r_q.idx == '0) begin
                r_d.busy = 1'b0;
            end else begin
                r_d.idx = r_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = r_q.busy;
    assign trial      = r_q.busy ? (r_q.acc | (W'(1) << r_q.idx)) : '0;
    assign done       = r_q.busy && (r_q.idx == '0);
    assign final_code = {r_q.acc[W-1:1], comp};
endmodule

// File: rtl/sar_bus_mux.sv
module sar_bus_mux #(
    parameter int RES_BITS = 12,
    parameter int BUS_W    = 8
) (
    input  logic [RES_BITS-1:0] result,
    input  logic                bipolar,
    input  logic                byte_hi,
    input  logic                cs_n,
    input  logic                rd_n,
    output logic [BUS_W-1:0]    dout,
    output logic                dout_oe
);
    localparam int HI_BITS = RES_BITS - BUS_W;
    localparam int FILL    = BUS_W - HI_BITS;

    logic [BUS_W-1:0] hi_word;
    logic             fill_bit;

    assign fill_bit = bipolar & result[RES_BITS-1];
    assign hi_word  = {{FILL{fill_bit}}, result[RES_BITS-1:BUS_W]};
    assign dout     = byte_hi ? hi_word : result[BUS_W-1:0];
    assign dout_oe  = ~cs_n & ~rd_n;
endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 12,
    parameter int BUS_W    = 8,
    parameter int ACQ_CLKS = 6,
    parameter int SYNC_STG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic                byte_hi,
    input  logic                shdn_n,
    input  logic [BUS_W-1:0]    din,
    input  logic                comp,
    output logic [BUS_W-1:0]    dout,
    output logic                dout_oe,
    output logic                irq_n,
    output logic [CB_CH_W-1:0]  chan_sel,
    output logic                range_hi,
    output logic                bipolar,
    output logic                int_clk_sel,
    output logic                track,
    output logic [RES_BITS-1:0] dac_code,
    output logic                pd_standby,
    output logic                pd_full
);
    localparam int CW = $clog2(ACQ_CLKS + 1);

    typedef struct packed {
        seq_state_e           state;
        logic [CW-1:0]        cnt;
        logic [BUS_W-1:0]     din1;
        logic [BUS_W-1:0]     din2;
        logic [BUS_W-1:0]     hold;
        logic [CB_CH_W-1:0]   chan;
        logic                 rng;
        logic                 bip;
        logic                 clk_int;
        logic [1:0]           pd_req;
        logic                 hw_off;
        logic                 irq_n;
        logic [RES_BITS-1:0]  result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic wr_rise, wr_fall, wr_low, rd_fall, shdn_lo;
    logic stp_start, stp_cancel, stp_busy, stp_done;
    logic [RES_BITS-1:0] stp_trial, stp_final;
    logic [1:0] new_pd;
    logic       new_acq;

    sar_strobe_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .shdn_n  (shdn_n),
        .wr_rise (wr_rise),
        .wr_fall (wr_fall),
        .wr_low  (wr_low),
        .rd_fall (rd_fall),
        .shdn_lo (shdn_lo)
    );

    sar_stepper #(.W(RES_BITS)) i_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (stp_start),
        .cancel     (stp_cancel),
        .comp       (comp),
        .trial      (stp_trial),
        .busy       (stp_busy),
        .done       (stp_done),
        .final_code (stp_final)
    );

    sar_bus_mux #(.RES_BITS(RES_BITS), .BUS_W(BUS_W)) i_mux (
        .result  (r_q.result),
        .bipolar (r_q.bip),
        .byte_hi (byte_hi),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    assign new_pd  = r_q.hold[CB_PD_LSB +: 2];
    assign new_acq = r_q.hold[CB_ACQ];

    always_comb begin
        r_d        = r_q;
        stp_start  = 1'b0;
        stp_cancel = 1'b0;

        r_d.din1 = din;
        r_d.din2 = r_q.din1;
        if (wr_low) begin
            r_d.hold = r_q.din2;
        end
        if (rd_fall) begin
            r_d.irq_n = 1'b1;
        end

        case (r_q.state)
            ST_ACQI: begin
                if (r_q.cnt == CW'(ACQ_CLKS - 1)) begin
                    stp_start = 1'b1;
                    r_d.state = ST_CONV;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_CONV: begin
                if (stp_done && !(wr_rise || shdn_lo)) begin
                    r_d.result = stp_final;
                    r_d.irq_n  = 1'b0;
                    r_d.pd_req = '0;
                    if (r_q.pd_req[1]) begin
                        r_d.state = r_q.pd_req[0] ? ST_FULL : ST_STBY;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_STBY, ST_FULL: begin
                if (wr_fall && !r_q.hw_off) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: ;
        endcase

        if (wr_rise && !shdn_lo) begin
            r_d.chan  = r_q.hold[CB_CH_LSB +: CB_CH_W];
            r_d.bip   = r_q.hold[CB_BIP];
            r_d.rng   = r_q.hold[CB_RNG];
            r_d.irq_n = 1'b1;
            if (!new_pd[1]) begin
                r_d.clk_int = new_pd[0];
                r_d.pd_req  = '0;
            end else begin
                r_d.pd_req = new_pd;
            end
            stp_cancel = (r_q.state == ST_CONV);
            stp_start  = 1'b0;
            if ((r_q.state == ST_ACQE) && !new_acq) begin
                stp_start = 1'b1;
                r_d.state = ST_CONV;
            end else if (new_acq) begin
                r_d.state = ST_ACQE;
            end else begin
                r_d.state = ST_ACQI;
                r_d.cnt   = '0;
            end
        end

        if (shdn_lo) begin
            r_d.state  = ST_FULL;
            r_d.hw_off = 1'b1;
            stp_start  = 1'b0;
            stp_cancel = 1'b1;
        end else if (r_q.hw_off) begin
            r_d.state  = ST_IDLE;
            r_d.hw_off = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.irq_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_n       = r_q.irq_n;
    assign chan_sel    = r_q.chan;
    assign range_hi    = r_q.rng;
    assign bipolar     = r_q.bip;
    assign int_clk_sel = r_q.clk_int;
    assign track       = (r_q.state == ST_ACQI) || (r_q.state == ST_ACQE);
    assign dac_code    = stp_trial;
    assign pd_standby  = (r_q.state == ST_STBY);
    assign pd_full     = (r_q.state == ST_FULL);
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
    parameter int CONV_BITS = 12,
    parameter int BUS_W     = 8,
    parameter int HI_BITS   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_n,
    input logic             converting,
    input logic             track,
    input logic             pd_standby,
    input logic             pd_full,
    input logic             shdn_lo,
    input logic             wr_rise,
    input logic             dout_oe,
    input logic             byte_hi,
    input logic             bipolar,
    input logic [BUS_W-1:0] dout
);
    localparam int KW = $clog2(CONV_BITS + 1);

    logic [KW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (converting && (run_q != KW'(CONV_BITS))) begin
            run_q <= run_q + 1'b1;
        end else if (!converting) begin
            run_q <= '0;
        end
    end

    AST_CONV_TWELVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(converting) && ($past(run_q) == KW'(CONV_BITS - 1)))); // R5

    AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && !shdn_lo) |=> irq_n); // R6

    AST_SOFT_PD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_standby) |-> $fell(irq_n)); // R8

    AST_SHDN_STOPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_lo |=> (pd_full && !track && !converting)); // R9

    AST_HIGH_NIBBLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && byte_hi) |->
            (dout[BUS_W-1:HI_BITS] ==
             (bipolar ? {(BUS_W-HI_BITS){dout[HI_BITS-1]}} : {(BUS_W-HI_BITS){1'b0}}))); // R10
endmodule

bind adc_sar_sequencer sar_seq_checker #(
    .CONV_BITS (RES_BITS),
    .BUS_W     (BUS_W),
    .HI_BITS   (RES_BITS - BUS_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_n      (irq_n),
    .converting (stp_busy),
    .track      (track),
    .pd_standby (pd_standby),
    .pd_full    (pd_full),
    .shdn_lo    (shdn_lo),
    .wr_rise    (wr_rise),
    .dout_oe    (dout_oe),
    .byte_hi    (byte_hi),
    .bipolar    (bipolar),
    .dout       (dout)
);

// File: tb/test_adc_sar_sequencer.sv
module test_adc_sar_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, byte_hi = 1'b0, shdn_n = 1'b1;
    logic [7:0]  din = 8'h00;
    logic        comp;
    logic [7:0]  dout;
    logic        dout_oe, irq_n, range_hi, bipolar, int_clk_sel, track, pd_standby, pd_full;
    logic [2:0]  chan_sel;
    logic [11:0] dac_code;
    logic [11:0] vin = 12'h000;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // comparator model: keep the trial bit while the trial code does not exceed the input
    assign comp = (dac_code <= vin);

    adc_sar_sequencer i_adc_sar_sequencer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .byte_hi(byte_hi), .shdn_n(shdn_n), .din(din), .comp(comp),
        .dout(dout), .dout_oe(dout_oe), .irq_n(irq_n), .chan_sel(chan_sel),
        .range_hi(range_hi), .bipolar(bipolar), .int_clk_sel(int_clk_sel),
        .track(track), .dac_code(dac_code), .pd_standby(pd_standby), .pd_full(pd_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // drive a control byte; returns at the negedge where wr_n has just risen
    task automatic wr_byte(input logic [7:0] b);
        din  = b;
        wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic rd_word(output logic [7:0] lo, output logic [7:0] hi);
        rd_n = 1'b0; byte_hi = 1'b0;
        #1 lo = dout;
        byte_hi = 1'b1;
        #1 hi = dout;
        @(negedge clk);
        rd_n = 1'b1; byte_hi = 1'b0;
    endtask

    task automatic cnt_to_irq(input int start, output int n, output int tr);
        n = start; tr = 0;
        while (irq_n && n < 80) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (track) tr++;
        end
    endtask

    task automatic t_reset;
        chk_eq("R11 irq_n after reset", irq_n, 1);
        chk_eq("R11 clock select after reset", int_clk_sel, 0);
        chk_eq("R11 power-down after reset", {pd_standby, pd_full}, 0);
        chk_eq("R11 track after reset", track, 0);
        chk_eq("R10 bus idle", dout_oe, 0);
    endtask

    task automatic t_int_acq;
        int n, tr; logic [7:0] lo, hi;
        vin = 12'h5A3;
        wr_byte(8'h15);
        cnt_to_irq(0, n, tr);
        chk_eq("R3 edges to irq", n, 21);
        chk_eq("R3 track clocks", tr, 6);
        chk_eq("R1 channel", chan_sel, 5);
        chk_eq("R1 range/polarity", {range_hi, bipolar}, 2'b10);
        chk_eq("R2 external clock", int_clk_sel, 0);
        rd_n = 1'b0; #1;
        chk_eq("R10 bus enabled on read", dout_oe, 1);
        rd_n = 1'b1; #1;
        rd_word(lo, hi);
        chk_eq("R5 R10 low byte", lo, 8'hA3);
        chk_eq("R10 unipolar high nibble zero fill", hi, 8'h05);
        repeat (3) @(negedge clk);
        chk_eq("R6 read clears irq", irq_n, 1);
    endtask

    task automatic t_ext_acq;
        int n, tr; logic [7:0] lo, hi;
        vin = 12'hC31;
        wr_byte(8'h6A);
        repeat (10) @(negedge clk);
        chk_eq("R4 open acquisition tracks", track, 1);
        chk_eq("R4 no irq while open", irq_n, 1);
        chk_eq("R2 internal clock", int_clk_sel, 1);
        wr_byte(8'h6A);
        repeat (10) @(negedge clk);
        chk_eq("R4 restart keeps tracking", track, 1);
        wr_byte(8'h4A);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_eq("R5 first trial code is MSB", dac_code, 12'h800);
        chk_eq("R4 tracking ends at conversion", track, 0);
        cnt_to_irq(3, n, tr);
        chk_eq("R4 edges to irq", n, 15);
        chk_eq("R1 bipolar and channel", {bipolar, range_hi, chan_sel}, 5'b10010);
        rd_word(lo, hi);
        chk_eq("R5 low byte", lo, 8'h31);
        chk_eq("R10 bipolar sign fill", hi, 8'hFC);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_abort;
        int n, tr; logic [7:0] lo, hi;
        vin = 12'h111;
        wr_byte(8'h00);
        cnt_to_irq(0, n, tr);
        chk_eq("R6 irq low after conversion", irq_n, 0);
        vin = 12'h222;
        wr_byte(8'h00);
        repeat (3) @(negedge clk);
        chk_eq("R6 write clears irq", irq_n, 1);
        repeat (9) @(negedge clk);
        vin = 12'h333;
        wr_byte(8'h01);
        rd_word(lo, hi);
        chk_eq("R7 old result kept after abort", lo, 8'h11);
        cnt_to_irq(1, n, tr);
        chk_eq("R7 aborted conversion raises no irq", n, 21);
        rd_word(lo, hi);
        chk_eq("R7 new result", {hi, lo}, 16'h0333);
        chk_eq("R1 channel one", chan_sel, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_coincide;
        int n, tr, low_seen; logic [7:0] lo, hi;
        vin = 12'h444;
        low_seen = 0;
        wr_byte(8'h20);
        repeat (5) @(negedge clk);
        wr_byte(8'h00);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!irq_n) low_seen++;
        end
        wr_byte(8'h00);
        rd_word(lo, hi);
        chk_eq("R7 coincident write keeps old result", lo, 8'h33);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!irq_n) low_seen++;
        end
        chk_eq("R7 coincident completion gives no irq", low_seen, 0);
        chk_eq("R7 new acquisition after coincident write", track, 1);
        cnt_to_irq(0, n, tr);
        rd_word(lo, hi);
        chk_eq("R7 result after coincident restart", lo, 8'h44);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_softpd;
        int n, tr; logic [7:0] lo, hi;
        vin = 12'h0F0;
        wr_byte(8'h40);
        cnt_to_irq(0, n, tr);
        rd_word(lo, hi);
        repeat (3) @(negedge clk);
        wr_byte(8'h83);
        repeat (4) @(negedge clk);
        chk_eq("R8 standby waits for conversion", pd_standby, 0);
        chk_eq("R8 acquisition runs before standby", track, 1);
        cnt_to_irq(4, n, tr);
        chk_eq("R8 edges to irq with standby request", n, 21);
        @(negedge clk);
        chk_eq("R8 standby after conversion", pd_standby, 1);
        chk_eq("R2 clock kept by standby code", int_clk_sel, 1);
        rd_word(lo, hi);
        chk_eq("R8 readable in standby", lo, 8'hF0);
        repeat (3) @(negedge clk);
        wr_byte(8'h03);
        @(negedge clk);
        chk_eq("R8 write falling edge wakes", pd_standby, 0);
        cnt_to_irq(0, n, tr);
        chk_eq("R2 external clock after 00 code", int_clk_sel, 0);
        rd_word(lo, hi);
        repeat (3) @(negedge clk);
        wr_byte(8'hC0);
        cnt_to_irq(0, n, tr);
        @(negedge clk);
        chk_eq("R8 full power-down after conversion", pd_full, 1);
        chk_eq("R2 clock kept by full code", int_clk_sel, 0);
        rd_word(lo, hi);
        chk_eq("R8 readable in full power-down", lo, 8'hF0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_shdn;
        logic [7:0] lo, hi;
        vin = 12'h555;
        wr_byte(8'h00);
        repeat (14) @(negedge clk);
        shdn_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R9 shutdown forces full power-down", pd_full, 1);
        chk_eq("R9 shutdown stops conversion", {track, dac_code}, 0);
        wr_byte(8'h07);
        repeat (6) @(negedge clk);
        chk_eq("R9 write ignored in shutdown", {track, chan_sel}, 0);
        chk_eq("R9 no irq from aborted conversion", irq_n, 1);
        shdn_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R9 release returns to idle", pd_full, 0);
        rd_word(lo, hi);
        chk_eq("R9 result unchanged by shutdown", lo, 8'hF0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_cs;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        wr_byte(8'h07);
        repeat (5) @(negedge clk);
        chk_eq("R12 write ignored with cs_n high", {track, chan_sel}, 0);
        repeat (25) @(negedge clk);
        chk_eq("R12 no irq with cs_n high", irq_n, 1);
        rd_n = 1'b0; #1;
        chk_eq("R10 R12 bus released with cs_n high", dout_oe, 0);
        rd_n = 1'b1;
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_int_acq();
        t_ext_acq();
        t_abort();
        t_coincide();
        t_softpd();
        t_shdn();
        t_cs();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule